// File: doc/BRIEF.md
# MMU Control and Fault Status Register File

This block is the software-visible register set of a memory management unit. It holds the MMU control word, the context table base, the current context number, and two pairs of fault registers. One pair is for synchronous translation faults (status and virtual address). The other pair is for asynchronous bus errors (status and physical address). Software reaches every register through a simple register bus with one read strobe and one write strobe. The read data is combinational from the address.

The translation logic reports each fault as a one-cycle pulse. The pulse carries a fault type, a table level, an access type, an address space number, an address and a flag that says whether that address means anything. The block latches the report and raises a one-cycle trap request to the processor. When the control word selects no-fault mode, the report is still latched but the trap is withheld. The one exception is the exempt address space, which always traps.

A second fault that arrives before software has read the status register sets an overwrite flag. A read of the status register clears that flag. The bus error side records which of three error kinds occurred, the top four bits of the 36-bit physical address and an occurred flag. The low 32 address bits go to a separate register.

Top module: `mmu_regfile`

## Requirements
- R1: After reset the control register reads IMPL_ID in bits 31:28 and VERSION_ID in bits 27:24 with all other bits zero. Every other register reads zero and trap_req is low.
- R2: The control register (offset 0x000) stores a write to bits 23:8 (system control), bit 7 (store ordering), bit 1 (no-fault) and bit 0 (enable). Bits 31:24 keep their fixed ID values and bits 6:2 read zero whatever is written. Bit 0 drives xlat_en and bit 7 drives pso_mode.
- R3: The context table pointer (offset 0x100) stores bits 31:2 of a write. Bits 1:0 always read zero. Bits 31:2 appear on ctp_base.
- R4: The context register (offset 0x200) stores the low CTX_W bits of a write, reads them zero-extended and drives ctx_id.
- R5: A fault pulse loads the fault status register (offset 0x300) with the layout: bits 17:10 external error, bits 9:8 level, bits 7:5 access type, bits 4:2 fault type, bit 1 address valid. Bits 31:18 read zero.
- R6: The fault address register (offset 0x400) loads flt_addr only when flt_addr_ok is high with the fault pulse. Otherwise it keeps its previous value.
- R7: With no-fault clear, trap_req is high in the cycle after every fault pulse. trap_req is low in the cycle after a cycle with no fault pulse.
- R8: With no-fault set, a fault pulse is still latched but raises no trap. A fault whose flt_space equals TRAP_SPACE (9) traps regardless.
- R9: Status bit 0 (overwrite) is set when a fault arrives while a previously latched fault has not yet been read. A read at offset 0x300 clears it. A fault arriving in the same cycle as that read leaves it clear.
- R10: A bus error pulse loads the asynchronous status (offset 0x500) with bit 12 uncorrectable, bit 11 timeout, bit 10 bus error, bits 7:4 address bits 35:32 and bit 0 set, other bits zero. It also loads address bits 31:0 into offset 0x600.
- R11: Writes to offsets 0x300 through 0x600 change nothing. A read at any offset other than the seven mapped ones (for example 0x700) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears overwrite on status read) |
| bus_addr | input | 11 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| flt_valid | input | 1 | Fault report pulse |
| flt_type | input | 3 | Fault type code |
| flt_level | input | 2 | Table level of the fault |
| flt_access | input | 3 | Access type code |
| flt_space | input | 8 | Address space of the faulting access |
| flt_ebe | input | 8 | External bus error bits |
| flt_addr | input | 32 | Faulting virtual address |
| flt_addr_ok | input | 1 | flt_addr is meaningful |
| afe_valid | input | 1 | Asynchronous bus error pulse |
| afe_uce | input | 1 | Uncorrectable error |
| afe_bto | input | 1 | Bus timeout |
| afe_berr | input | 1 | Generic bus error |
| afe_addr | input | 36 | Physical address of the bus error |
| trap_req | output | 1 | One-cycle trap request to the processor |
| xlat_en | output | 1 | Translation enable |
| pso_mode | output | 1 | Store ordering mode bit |
| ctx_id | output | 8 | Current context number |
| ctp_base | output | 30 | Context table pointer bits 31:2 |

## Verification
A table of fault reports is applied. The table varies the no-fault mode, the address space (exempt and not exempt), every field value and the address valid flag. Each report is checked for trap or no trap and for the exact status and address words. This separates trap suppression from the exemption and shows that a report with the valid flag low keeps the old address. Directed sequences then cover three cases for the overwrite flag: two faults with no read between, a second read after the flag is set, and a fault that coincides with the read. They also write all ones to every register, to show which bits hold and which read back fixed or zero, and they check the bus error capture.

// File: rtl/mmu_reg_pkg.sv
// Package: shared register selects and the fault report record for the
// MMU register file. Assumes 32-bit registers on a 256-byte offset grid.
package mmu_reg_pkg;
    localparam int REG_W    = 32;
    localparam int SEL_W    = 3;
    localparam int ADDR_W   = 11;
    localparam int SPACE_W  = 8;
    localparam int EBE_W    = 8;
    localparam int PADDR_W  = 36;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 3'd0,
        SEL_CTP   = 3'd1,
        SEL_CTX   = 3'd2,
        SEL_FSR   = 3'd3,
        SEL_FAR   = 3'd4,
        SEL_AFSR  = 3'd5,
        SEL_AFAR  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [EBE_W-1:0] ebe;
        logic [1:0]       level;
        logic [2:0]       access;
        logic [2:0]       ftype;
        logic             addr_ok;
    } fault_rpt_t;
endpackage

// File: rtl/mmu_ctrl_regs.sv
// Module: control word, context table pointer and context number.
// Assumes one write strobe per register, already decoded by the parent.
module mmu_ctrl_regs #(
    parameter logic [3:0] IMPL_ID    = 4'h3,
    parameter logic [3:0] VERSION_ID = 4'h1,
    parameter int         CTX_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic        wr_ctp,
    input  logic        wr_ctx,
    input  logic [31:0] wdata,
    output logic [31:0] ctrl_word,
    output logic [31:0] ctp_word,
    output logic [31:0] ctx_word,
    output logic        en_bit,
    output logic        pso_bit,
    output logic        nofault_bit,
    output logic [CTX_W-1:0] ctx_q,
    output logic [29:0] ctp_q
);
    logic [15:0] sysctl_q;
    logic        unused_wbits;

    assign unused_wbits = &{1'b0, wdata[31:24], wdata[6:2]};

    // control word writable fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sysctl_q    <= '0;
            pso_bit     <= 1'b0;
            nofault_bit <= 1'b0;
            en_bit      <= 1'b0;
        end else if (wr_ctrl) begin
            sysctl_q    <= wdata[23:8];
            pso_bit     <= wdata[7];
            nofault_bit <= wdata[1];
            en_bit      <= wdata[0];
        end
    end

    // context table pointer, upper 30 bits only
    always_ff @(posedge clk) begin
        if (!rst_n)      ctp_q <= '0;
        else if (wr_ctp) ctp_q <= wdata[31:2];
    end

    // context number
    always_ff @(posedge clk) begin
        if (!rst_n)      ctx_q <= '0;
        else if (wr_ctx) ctx_q <= wdata[CTX_W-1:0];
    end

    assign ctrl_word = {IMPL_ID, VERSION_ID, sysctl_q, pso_bit, 5'b0, nofault_bit, en_bit};
    assign ctp_word  = {ctp_q, 2'b00};

    generate
        if (CTX_W < 32) begin : g_ctx_pad
            logic unused_ctx_hi;
            assign unused_ctx_hi = &{1'b0, wdata[31:CTX_W]};
            assign ctx_word = {{(32-CTX_W){1'b0}}, ctx_q};
        end else begin : g_ctx_full
            assign ctx_word = ctx_q;
        end
    endgenerate
endmodule

// File: rtl/mmu_sync_fault.sv
// Module: synchronous fault status/address capture and trap request.
// Assumes fault reports are single-cycle pulses; rd_fsr is a status read.
module mmu_sync_fault
    import mmu_reg_pkg::*;
#(
    parameter int                  SPACE_BITS = SPACE_W,
    parameter logic [SPACE_W-1:0]  TRAP_SPACE = 8'd9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rpt_valid,
    input  fault_rpt_t            rpt,
    input  logic [SPACE_BITS-1:0] rpt_space,
    input  logic [31:0]           rpt_addr,
    input  logic                  rd_fsr,
    input  logic                  nofault,
    output logic [31:0]           fsr_word,
    output logic [31:0]           far_word,
    output logic                  trap_q
);
    fault_rpt_t fsr_q;
    logic       ow_q;
    logic       unread_q;
    logic       exempt;

    assign exempt = (rpt_space == TRAP_SPACE);

    // latch fault fields on each report
    always_ff @(posedge clk) begin
        if (!rst_n)         fsr_q <= '0;
        else if (rpt_valid) fsr_q <= rpt;
    end

    // unread tracking and overwrite flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unread_q <= 1'b0;
            ow_q     <= 1'b0;
        end else if (rpt_valid) begin
            unread_q <= 1'b1;
            ow_q     <= unread_q && !rd_fsr;
        end else if (rd_fsr) begin
            unread_q <= 1'b0;
            ow_q     <= 1'b0;
        end
    end

    // fault address loads only when marked valid
    always_ff @(posedge clk) begin
        if (!rst_n)                       far_word <= '0;
        else if (rpt_valid && rpt.addr_ok) far_word <= rpt_addr;
    end

    // trap request, withheld in no-fault mode unless exempt space
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= rpt_valid && (!nofault || exempt);
    end

    assign fsr_word = {14'b0, fsr_q.ebe, fsr_q.level, fsr_q.access,
                       fsr_q.ftype, fsr_q.addr_ok, ow_q};
endmodule

// File: rtl/mmu_async_fault.sv
// Module: asynchronous bus error status and address capture.
// Assumes error reports are single-cycle pulses; the latest report wins.
module mmu_async_fault
    import mmu_reg_pkg::*;
#(
    parameter int PA_W = PADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            err_valid,
    input  logic            err_uce,
    input  logic            err_bto,
    input  logic            err_berr,
    input  logic [PA_W-1:0] err_addr,
    output logic [31:0]     afsr_word,
    output logic [31:0]     afar_word
);
    localparam int HI_W = PA_W - 32;

    logic [2:0]      kind_q;
    logic [HI_W-1:0] hi_q;
    logic            occ_q;

    // capture error kind, high address bits and occurred flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= '0;
            hi_q      <= '0;
            occ_q     <= 1'b0;
            afar_word <= '0;
        end else if (err_valid) begin
            kind_q    <= {err_uce, err_bto, err_berr};
            hi_q      <= err_addr[PA_W-1:32];
            occ_q     <= 1'b1;
            afar_word <= err_addr[31:0];
        end
    end

    assign afsr_word = {19'b0, kind_q, 2'b0, {(4-HI_W){1'b0}}, hi_q, 3'b0, occ_q};
endmodule

// File: rtl/mmu_regfile.sv
// Module: MMU register file top; decodes the register bus, muxes reads
// and instantiates control, synchronous fault and bus error sections.
// Assumes offsets on a 0x100 grid; low 8 offset bits must be zero to hit.
module mmu_regfile
    import mmu_reg_pkg::*;
#(
    parameter logic [3:0]         IMPL_ID    = 4'h3,
    parameter logic [3:0]         VERSION_ID = 4'h1,
    parameter int                 CTX_W      = 8,
    parameter logic [SPACE_W-1:0] TRAP_SPACE = 8'd9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               flt_valid,
    input  logic [2:0]         flt_type,
    input  logic [1:0]         flt_level,
    input  logic [2:0]         flt_access,
    input  logic [SPACE_W-1:0] flt_space,
    input  logic [EBE_W-1:0]   flt_ebe,
    input  logic [31:0]        flt_addr,
    input  logic               flt_addr_ok,
    input  logic               afe_valid,
    input  logic               afe_uce,
    input  logic               afe_bto,
    input  logic               afe_berr,
    input  logic [PADDR_W-1:0] afe_addr,
    output logic               trap_req,
    output logic               xlat_en,
    output logic               pso_mode,
    output logic [CTX_W-1:0]   ctx_id,
    output logic [29:0]        ctp_base
);
    reg_sel_e   sel;
    logic       hit;
    logic       rd_fsr;
    logic       ctl_nofault;
    fault_rpt_t rpt;
    logic [31:0] ctrl_word, ctp_word, ctx_word;
    logic [31:0] fsr_word, far_word, afsr_word, afar_word;

    assign hit    = (bus_addr[7:0] == 8'h00);
    assign sel    = hit ? reg_sel_e'(bus_addr[10:8]) : SEL_NONE;
    assign rd_fsr = bus_rd && (sel == SEL_FSR);
    assign rpt    = '{ebe: flt_ebe, level: flt_level, access: flt_access,
                      ftype: flt_type, addr_ok: flt_addr_ok};

    mmu_ctrl_regs #(
        .IMPL_ID(IMPL_ID), .VERSION_ID(VERSION_ID), .CTX_W(CTX_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(bus_wr && sel == SEL_CTRL),
        .wr_ctp(bus_wr && sel == SEL_CTP),
        .wr_ctx(bus_wr && sel == SEL_CTX),
        .wdata(bus_wdata),
        .ctrl_word(ctrl_word), .ctp_word(ctp_word), .ctx_word(ctx_word),
        .en_bit(xlat_en), .pso_bit(pso_mode), .nofault_bit(ctl_nofault),
        .ctx_q(ctx_id), .ctp_q(ctp_base)
    );

    mmu_sync_fault #(
        .SPACE_BITS(SPACE_W), .TRAP_SPACE(TRAP_SPACE)
    ) i_sync (
        .clk(clk), .rst_n(rst_n),
        .rpt_valid(flt_valid), .rpt(rpt), .rpt_space(flt_space),
        .rpt_addr(flt_addr), .rd_fsr(rd_fsr), .nofault(ctl_nofault),
        .fsr_word(fsr_word), .far_word(far_word), .trap_q(trap_req)
    );

    mmu_async_fault #(.PA_W(PADDR_W)) i_async (
        .clk(clk), .rst_n(rst_n),
        .err_valid(afe_valid), .err_uce(afe_uce), .err_bto(afe_bto),
        .err_berr(afe_berr), .err_addr(afe_addr),
        .afsr_word(afsr_word), .afar_word(afar_word)
    );

    // read data multiplexer
    always_comb begin
        unique case (sel)
            SEL_CTRL: bus_rdata = ctrl_word;
            SEL_CTP:  bus_rdata = ctp_word;
            SEL_CTX:  bus_rdata = ctx_word;
            SEL_FSR:  bus_rdata = fsr_word;
            SEL_FAR:  bus_rdata = far_word;
            SEL_AFSR: bus_rdata = afsr_word;
            SEL_AFAR: bus_rdata = afar_word;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mmu_regfile_chk.sv
// Module: property checker for mmu_regfile, attached by bind.
// Assumes the top's internal no-fault, status-read and status words.
module mmu_regfile_chk
    import mmu_reg_pkg::*;
#(
    parameter logic [SPACE_W-1:0] TRAP_SPACE = 8'd9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flt_valid,
    input logic [SPACE_W-1:0] flt_space,
    input logic               flt_addr_ok,
    input logic               trap_req,
    input logic               nofault,
    input logic               rd_fsr,
    input logic [31:0]        fsr_word,
    input logic [31:0]        far_word,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata
);
    a_r7_trap_raised: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !nofault |=> trap_req);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid |=> !trap_req);
    a_r8_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && nofault && flt_space != TRAP_SPACE |=> !trap_req);
    a_r8_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && flt_space == TRAP_SPACE |=> trap_req);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fsr |=> !fsr_word[0]);
    a_r6_far_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_valid && flt_addr_ok) |=> $stable(far_word));
    a_r5_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fsr_word[31:18] == 14'b0);
    a_r3_ctp_low: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 11'h100 |-> bus_rdata[1:0] == 2'b00);
    a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 11'h700 |-> bus_rdata == 32'h0);
endmodule

bind mmu_regfile mmu_regfile_chk #(.TRAP_SPACE(TRAP_SPACE)) i_chk (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_space(flt_space),
    .flt_addr_ok(flt_addr_ok), .trap_req(trap_req), .nofault(ctl_nofault),
    .rd_fsr(rd_fsr), .fsr_word(fsr_word), .far_word(far_word),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_mmu_regfile.sv
// Bench: fault vector table walked by one loop, then directed tests.
module test_mmu_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [10:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flt_valid = 0;
    logic [2:0]  flt_type = 0;
    logic [1:0]  flt_level = 0;
    logic [2:0]  flt_access = 0;
    logic [7:0]  flt_space = 0;
    logic [7:0]  flt_ebe = 0;
    logic [31:0] flt_addr = 0;
    logic        flt_addr_ok = 0;
    logic        afe_valid = 0, afe_uce = 0, afe_bto = 0, afe_berr = 0;
    logic [35:0] afe_addr = 0;
    logic        trap_req, xlat_en, pso_mode;
    logic [7:0]  ctx_id;
    logic [29:0] ctp_base;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    mmu_regfile i_mmu_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_level(flt_level),
        .flt_access(flt_access), .flt_space(flt_space), .flt_ebe(flt_ebe),
        .flt_addr(flt_addr), .flt_addr_ok(flt_addr_ok),
        .afe_valid(afe_valid), .afe_uce(afe_uce), .afe_bto(afe_bto),
        .afe_berr(afe_berr), .afe_addr(afe_addr),
        .trap_req(trap_req), .xlat_en(xlat_en), .pso_mode(pso_mode),
        .ctx_id(ctx_id), .ctp_base(ctp_base)
    );

    typedef struct packed {
        logic        nf;
        logic [7:0]  space;
        logic [2:0]  ft;
        logic [1:0]  lvl;
        logic [2:0]  acc;
        logic [7:0]  ebe;
        logic        ok;
        logic [31:0] addr;
        logic        trap;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h0A, 3'd1, 2'd1, 3'd0, 8'h00, 1'b1, 32'h1000_0004, 1'b1},
        '{1'b1, 8'h0A, 3'd2, 2'd3, 3'd4, 8'h01, 1'b1, 32'hDEAD_BEE0, 1'b0},
        '{1'b1, 8'h09, 3'd3, 2'd2, 3'd3, 8'h80, 1'b0, 32'h5555_0000, 1'b1},
        '{1'b0, 8'h09, 3'd4, 2'd0, 3'd7, 8'hFF, 1'b1, 32'hFFFF_FFFC, 1'b1},
        '{1'b1, 8'h08, 3'd5, 2'd1, 3'd5, 8'h3C, 1'b1, 32'h0000_0100, 1'b0},
        '{1'b0, 8'h00, 3'd6, 2'd2, 3'd6, 8'h42, 1'b0, 32'h0000_1234, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    // one fault pulse; with_rd also reads status in the same cycle
    task automatic fault(input vec_t v, input logic with_rd, output logic trap);
        @(negedge clk);
        flt_valid = 1; flt_type = v.ft; flt_level = v.lvl; flt_access = v.acc;
        flt_space = v.space; flt_ebe = v.ebe; flt_addr = v.addr; flt_addr_ok = v.ok;
        if (with_rd) begin bus_rd = 1; bus_addr = 11'h300; end
        @(posedge clk); #1;
        trap = trap_req;
        flt_valid = 0; bus_rd = 0;
    endtask

    function automatic logic [31:0] fsr_of(input vec_t v, input logic ow);
        return {14'b0, v.ebe, v.lvl, v.acc, v.ft, v.ok, ow};
    endfunction

    initial begin
        logic [31:0] d;
        logic        t;
        logic [31:0] far_exp;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(11'h000, d); check("R1 ctrl", d, 32'h3100_0000);
        rd(11'h100, d); check("R1 ctp", d, 0);
        rd(11'h200, d); check("R1 ctx", d, 0);
        rd(11'h300, d); check("R1 fsr", d, 0);
        rd(11'h400, d); check("R1 far", d, 0);
        rd(11'h500, d); check("R1 afsr", d, 0);
        rd(11'h600, d); check("R1 afar", d, 0);
        check("R1 trap", {31'b0, trap_req}, 0);

        // vector table: R5 R6 R7 R8
        far_exp = 0;
        for (int i = 0; i < NV; i++) begin
            wr(11'h000, {30'b0, VECS[i].nf, 1'b0});
            rd(11'h300, d);
            fault(VECS[i], 1'b0, t);
            check($sformatf("R7/R8 trap vec%0d", i), {31'b0, t}, {31'b0, VECS[i].trap});
            if (VECS[i].ok) far_exp = VECS[i].addr;
            rd(11'h300, d); check($sformatf("R5 fsr vec%0d", i), d, fsr_of(VECS[i], 1'b0));
            rd(11'h400, d); check($sformatf("R6 far vec%0d", i), d, far_exp);
        end
        wr(11'h000, 32'h0);
        @(negedge clk); #1 check("R7 no spurious trap", {31'b0, trap_req}, 0);

        // R2 control fields
        wr(11'h000, 32'hFFFF_FFFF);
        rd(11'h000, d); check("R2 ctrl all ones", d, 32'h31FF_FF83);
        check("R2 enable/pso out", {30'b0, xlat_en, pso_mode}, 32'h3);
        wr(11'h000, 32'h0000_0000);
        rd(11'h000, d); check("R2 ctrl cleared", d, 32'h3100_0000);

        // R3 context table pointer
        wr(11'h100, 32'hFFFF_FFFF);
        rd(11'h100, d); check("R3 ctp", d, 32'hFFFF_FFFC);
        check("R3 ctp_base", {2'b0, ctp_base}, 32'h3FFF_FFFF);

        // R4 context
        wr(11'h200, 32'h1234_ABCD);
        rd(11'h200, d); check("R4 ctx", d, 32'h0000_00CD);
        check("R4 ctx_id", {24'b0, ctx_id}, 32'hCD);

        // R9 overwrite
        rd(11'h300, d);
        fault(VECS[0], 1'b0, t);
        fault(VECS[1], 1'b0, t);
        rd(11'h300, d); check("R9 ow set", d, fsr_of(VECS[1], 1'b1));
        rd(11'h300, d); check("R9 ow cleared by read", d, fsr_of(VECS[1], 1'b0));
        fault(VECS[3], 1'b0, t);
        fault(VECS[4], 1'b1, t);
        rd(11'h300, d); check("R9 same-cycle read", d, fsr_of(VECS[4], 1'b0));

        // R10 asynchronous error
        @(negedge clk);
        afe_valid = 1; afe_uce = 1; afe_bto = 0; afe_berr = 1; afe_addr = 36'hA_1234_5678;
        @(posedge clk); #1 afe_valid = 0;
        rd(11'h500, d); check("R10 afsr", d, 32'h0000_14A1);
        rd(11'h600, d); check("R10 afar", d, 32'h1234_5678);

        // R11 status writes ignored, unmapped read zero
        wr(11'h300, 32'hFFFF_FFFF);
        wr(11'h400, 32'hFFFF_FFFF);
        wr(11'h500, 32'hFFFF_FFFF);
        wr(11'h600, 32'hFFFF_FFFF);
        rd(11'h300, d); check("R11 fsr unchanged", d, fsr_of(VECS[4], 1'b0));
        rd(11'h400, d); check("R11 far unchanged", d, 32'h0000_0100);
        rd(11'h500, d); check("R11 afsr unchanged", d, 32'h0000_14A1);
        rd(11'h600, d); check("R11 afar unchanged", d, 32'h1234_5678);
        wr(11'h700, 32'hFFFF_FFFF);
        rd(11'h700, d); check("R11 unmapped", d, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule